// File: doc/BRIEF.md
# Single-Channel Quadword DMA Engine

This block is one DMA channel. It copies a run of 128-bit quadwords from a source address in system memory to a destination in a peripheral window. Software fills in a source address, a destination offset and a quadword count, then writes the control register with the go bit set. The engine reads one quadword, writes it out, moves both addresses on by 16 bytes and decrements the count, and repeats until the count reaches zero.

On completion the engine clears the go bit and raises a sticky done flag, which drives the interrupt output. The destination offset is always added to a fixed peripheral base before it reaches the bus. A control write with go clear stops a running copy at the next quadword boundary. Because the count and the addresses are live registers, software can read them back to follow progress or to find out where a stopped copy ended.

Memory traffic uses a read-address channel, a read-data return, and a write channel that carries address and data together. Each channel has a valid/ready handshake. The engine keeps at most one quadword in flight.

Top module: `qw_dma_chan`

## Requirements
- R1: Registers are selected by `reg_addr[5:4]`, so they sit 16 bytes apart: 0 is control, 1 is source, 2 is destination offset, 3 is quadword count. Control bit 0 is GO and bit 1 is DONE. All registers read back through `reg_rdata`, zero-extended to 32 bits.
- R2: A control write with bit 0 set, made while idle with a non-zero count, sets GO and begins read requests, the first of them at the source register address.
- R3: Each quadword read is written to `DST_BASE` plus the destination offset register, with the data unchanged.
- R4: Each accepted quadword write decrements the count by 1 and advances the source and destination registers by 16.
- R5: When the last quadword is written, the count reads 0, GO reads 0 and DONE reads 1.
- R6: A start with a count of 0 sets DONE on the next clock, leaves GO at 0 and issues no memory request.
- R7: A control write with bit 0 clear, made during a copy, stops the copy after the quadword in progress. DONE stays 0, and the count then holds the number of quadwords not yet written.
- R8: While a copy is running, writes to the source, destination and count registers have no effect.
- R9: Writing control with bit 1 set clears DONE. The `irq` output equals DONE.
- R10: `rd_valid` and `wr_valid`, once raised, stay high with their address and data stable until the matching ready is seen.
- R11: After reset all registers read 0, `irq` is low and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Completion interrupt (DONE flag) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rdata_valid | input | 1 | Read data returned |
| rdata | input | DW | Returned quadword |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write byte address (base plus offset) |
| wr_data | output | DW | Quadword to write |

## Verification
The bench builds the engine with a 6-bit count and a peripheral base of 0x0010_0000. The narrow count makes the largest legal transfer, 63 quadwords, short enough to run in full. The non-zero base makes any missing or doubled base addition show up in the written addresses. The memory model can stall both ready signals, which exercises the hold rules under back-pressure.

// File: rtl/qw_dma_chan.sv
module qw_dma_chan #(
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int DW = 128,
  parameter logic [AW-1:0] DST_BASE = 32'h0004_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rdata_valid,
  input  logic [DW-1:0] rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} st_t;
  st_t st;

  logic [AW-1:0]    src, dst;
  logic [CNT_W-1:0] cnt;
  logic             go, done;
  logic [DW-1:0]    qbuf;

  wire [1:0] idx     = reg_addr[5:4];
  wire       ctrl_wr = reg_wr && idx == 2'd0;
  wire       idle    = st == S_IDLE;
  wire       stop_rq = ctrl_wr && !reg_wdata[0];
  wire       wr_fire = st == S_WR && wr_ready;

  assign rd_valid = st == S_RD;
  assign wr_valid = st == S_WR;
  assign rd_addr  = src;
  assign wr_addr  = DST_BASE + dst;
  assign wr_data  = qbuf;
  assign irq      = done;

  always_comb begin
    case (idx)
      2'd0:    reg_rdata = {30'd0, done, go};
      2'd1:    reg_rdata = 32'(src);
      2'd2:    reg_rdata = 32'(dst);
      default: reg_rdata = 32'(cnt);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      go   <= 1'b0;
      done <= 1'b0;
      qbuf <= '0;
    end else begin
      if (ctrl_wr && reg_wdata[1]) done <= 1'b0;
      if (stop_rq) go <= 1'b0;
      case (st)
        S_IDLE: begin
          if (reg_wr && idx == 2'd1) src <= AW'(reg_wdata);
          if (reg_wr && idx == 2'd2) dst <= AW'(reg_wdata);
          if (reg_wr && idx == 2'd3) cnt <= CNT_W'(reg_wdata);
          if (ctrl_wr && reg_wdata[0]) begin
            if (cnt == '0) done <= 1'b1;
            else begin
              go <= 1'b1;
              st <= S_RD;
            end
          end
        end
        S_RD:   if (rd_ready) st <= S_WAIT;
        S_WAIT: if (rdata_valid) begin
          qbuf <= rdata;
          st   <= S_WR;
        end
        S_WR:   if (wr_ready) begin
          cnt <= cnt - 1'b1;
          src <= src + STEP;
          dst <= dst + STEP;
          if (cnt == CNT_W'(1)) begin
            go   <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (!go || stop_rq) st <= S_IDLE;
          else st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: request held until accepted
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R4: one step per accepted write
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> cnt == $past(cnt) - 1'b1 && src == $past(src) + STEP);
  // R5: completion leaves count and go at zero
  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cnt == '0 && !go);
  // R6: zero-length start completes without traffic
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle && ctrl_wr && reg_wdata[0] && cnt == '0 |=> irq && !rd_valid && !go);
  // R8: count frozen against writes while busy
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && reg_wr && idx == 2'd3 && !wr_fire |=> cnt == $past(cnt));
endmodule

// File: tb/sim_qw_dma_chan.sv
module sim_qw_dma_chan;
  localparam int TCLK = 10;
  localparam int AW = 32;
  localparam int DW = 128;
  localparam int CW = 6;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, rd_valid, rd_ready = 0, rdata_valid = 0, wr_valid, wr_ready = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rdata = 0, wr_data;

  always #(TCLK/2) clk = ~clk;

  qw_dma_chan #(.AW(AW), .CNT_W(CW), .DW(DW), .DST_BASE(BASE)) u0 (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .rd_valid, .rd_ready, .rd_addr, .rdata_valid, .rdata,
    .wr_valid, .wr_ready, .wr_addr, .wr_data);

  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] md(input logic [31:0] a);
    return {a ^ 32'h1357_9bdf, ~a, a + 32'h11, a};
  endfunction

  // memory model
  bit stall = 0, pend = 0, hold_hi = 0;
  logic [31:0] pend_a = 0;
  int tick = 0, nrd = 0, nwr = 0;
  logic [31:0] rlog [256];
  logic [31:0] wlog_a [256];
  logic [DW-1:0] wlog_d [256];
  always @(negedge clk) begin
    tick++;
    rdata_valid = pend;
    rdata = md(pend_a);
    rd_ready = hold_hi ? 1'b0 : (!stall || (tick % 3 == 0));
    wr_ready = hold_hi ? 1'b0 : (!stall || (tick % 4 == 1));
    pend = 0;
    if (rd_valid && rd_ready) begin
      pend = 1; pend_a = rd_addr; rlog[nrd % 256] = rd_addr; nrd++;
    end
    if (wr_valid && wr_ready) begin
      wlog_a[nwr % 256] = wr_addr; wlog_d[nwr % 256] = wr_data; nwr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n);
    wreg(6'h10, s); wreg(6'h20, d); wreg(6'h30, n);
  endtask

  task automatic check_copy(input string tag, input logic [31:0] s, input logic [31:0] d,
                            input int n, input int r0, input int w0);
    chk(nrd - r0 == n, {tag, " R2 read count"}, nrd - r0, n);
    chk(nwr - w0 == n, {tag, " R3 write count"}, nwr - w0, n);
    for (int i = 0; i < n; i++) begin
      chk(rlog[(r0+i)%256] == s + 16*i, {tag, " R2 read addr"}, rlog[(r0+i)%256], s + 16*i);
      chk(wlog_a[(w0+i)%256] == BASE + d + 16*i, {tag, " R3 write addr"}, wlog_a[(w0+i)%256], BASE + d + 16*i);
      chk(wlog_d[(w0+i)%256] == md(s + 16*i), {tag, " R3 write data"}, wlog_d[(w0+i)%256], md(s + 16*i));
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rreg(6'(k * 16), v);
      chk(v == 0, "R11 reset reg", v, 0);
    end
    chk(!irq && !rd_valid && !wr_valid, "R11 reset outputs", {irq, rd_valid, wr_valid}, 0);
  endtask

  task automatic t_basic(input string tag, input logic [31:0] s, input logic [31:0] d, input int n);
    logic [31:0] v;
    int r0 = nrd, w0 = nwr;
    setup(s, d, n);
    rreg(6'h18, v); chk(v == s, "R1 source readback", v, s);
    rreg(6'h30, v); chk(v == n, "R1 count readback", v, n);
    wreg(6'h00, 32'h1);
    rreg(6'h00, v); chk(v[0] == 1, "R2 go set", v, 1);
    wait_irq();
    check_copy(tag, s, d, n, r0, w0);
    rreg(6'h30, v); chk(v == 0, "R5 count zero", v, 0);
    rreg(6'h00, v); chk(v == 32'h2, "R5 ctrl done no go", v, 2);
    rreg(6'h10, v); chk(v == s + 16*n, "R4 source advanced", v, s + 16*n);
    rreg(6'h20, v); chk(v == d + 16*n, "R4 dest advanced", v, d + 16*n);
    chk(irq == 1, "R9 irq equals done", irq, 1);
    wreg(6'h00, 32'h2);
    chk(irq == 0, "R9 done cleared", irq, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int r0 = nrd;
    wreg(6'h30, 0);
    wreg(6'h00, 32'h1);
    chk(irq == 1, "R6 done next clock", irq, 1);
    rreg(6'h00, v); chk(v == 32'h2, "R6 go stays clear", v, 2);
    repeat (5) @(negedge clk);
    chk(nrd == r0 && !rd_valid, "R6 no memory request", nrd - r0, 0);
    wreg(6'h00, 32'h2);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int w0 = nwr, done_n;
    setup(32'h0000_3000, 32'h40, 20);
    wreg(6'h00, 32'h1);
    for (int i = 0; i < 500 && nwr - w0 < 3; i++) @(negedge clk);
    wreg(6'h00, 32'h0);
    repeat (20) @(negedge clk);
    done_n = nwr - w0;
    chk(done_n >= 3 && done_n < 20, "R7 stopped early", done_n, 3);
    rreg(6'h30, v); chk(v == 20 - done_n, "R7 remaining count", v, 20 - done_n);
    chk(irq == 0 && !rd_valid && !wr_valid, "R7 no done, idle", {irq, rd_valid, wr_valid}, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int r0 = nrd, w0 = nwr;
    setup(32'h0000_5000, 32'h100, 4);
    wreg(6'h00, 32'h1);
    wreg(6'h10, 32'hdead_0000);
    wreg(6'h20, 32'h0bad_0000);
    wreg(6'h30, 1);
    wait_irq();
    check_copy("R8 busy writes ignored", 32'h5000, 32'h100, 4, r0, w0);
    rreg(6'h10, v); chk(v == 32'h5040, "R8 source unchanged", v, 32'h5040);
    wreg(6'h00, 32'h2);
  endtask

  task automatic t_hold();
    int w0 = nwr;
    logic [31:0] a;
    setup(32'h0000_7000, 32'h0, 1);
    hold_hi = 1;
    wreg(6'h00, 32'h1);
    repeat (2) @(negedge clk);
    a = rd_addr;
    repeat (3) @(negedge clk);
    chk(rd_valid && rd_addr == a, "R10 read held", rd_addr, a);
    hold_hi = 0;
    for (int i = 0; i < 50 && !wr_valid; i++) @(negedge clk);
    hold_hi = 1;
    @(negedge clk); a = wr_addr;
    repeat (3) @(negedge clk);
    chk(wr_valid && wr_addr == a && nwr == w0, "R10 write held", wr_addr, a);
    hold_hi = 0;
    wait_irq();
    chk(nwr - w0 == 1, "R10 single write", nwr - w0, 1);
    wreg(6'h00, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic("R2 basic", 32'h0000_1000, 32'h0000_0200, 3);
    stall = 1;
    t_basic("R3 stalled", 32'h0000_2010, 32'h0000_0030, 5);
    stall = 0;
    t_zero();
    t_stop();
    t_busy_ignore();
    t_hold();
    t_basic("R4 max count", 32'h0001_0000, 32'h0000_1000, 63);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule